// File: doc/BRIEF.md
# Programmable Serial Sequence Detector

The block samples one serial bit on each clock where the bit-valid input is high. It raises a match flag whenever the three most recent valid bits equal a 3-bit pattern supplied on an input port. Matches may share bits with one another, so a pattern that overlaps itself is reported at every position where it completes.

The block does not compare a window of stored bits. A three-state progress machine held in two flip-flops records how many leading pattern bits have been seen. The match flag is a Mealy output: it is formed from the progress state and the bit being presented, in the same cycle. Two 8-bit history words are provided for observation. One holds the most recent input bits and the other holds the most recent match results. Both shift toward the least significant end, and the newest value enters at the most significant bit. The detector never reads either history word.

Top module: `pattern_spotter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the progress state goes to "nothing matched" (encoding 00) and both history words are cleared to zero.
- R2: `match_o` is high in the cycle where `bit_vld` is high and the presented bit completes the pattern. `pattern_i[2]` is the oldest of the three bits and `pattern_i[0]` is the newest. The flag is combinational from the current progress state and `din`.
- R3: Matches overlap. With pattern 010, the valid stream 0,1,0,1,0,1,0 yields exactly three matches.
- R4: The progress state holds 0, 1 or 2 matched leading pattern bits, encoded 00, 01 and 10. After each valid bit it becomes the length of the longest proper leading part of the pattern that ends the bits just seen. Encoding 11 never occurs, and it would fall back to 00 on the next valid bit.
- R5: On each valid bit, `in_hist_o` shifts right by one position and the new bit enters bit 7.
- R6: On each valid bit, `match_hist_o` shifts right by one position and that cycle's `match_o` value enters bit 7.
- R7: When `bit_vld` is low, the progress state and both history words hold, and `match_o` stays low whatever `din` is.
- R8: A change on `pattern_i` takes effect with the next valid bit and does not clear the progress state. The count already held is then judged against the new pattern's leading bits.
- R9: Every one of the eight pattern values is detected correctly with a steady pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Qualifies `din` for this cycle |
| din | input | 1 | Serial data bit |
| pattern_i | input | 3 | Pattern to detect, bit 2 oldest |
| match_o | output | 1 | Pattern completed by the current bit |
| in_hist_o | output | 8 | Last eight valid input bits, newest in bit 7 |
| match_hist_o | output | 8 | Last eight match results, newest in bit 7 |

## Verification
The hardest case to reach is a progress count that was earned under one pattern and is then interpreted under another. In that case the detector's answer differs from a plain three-bit window compare. To reach it, the stimulus drives the machine to two matched bits under pattern 000 and then switches the pattern to 011 before the next valid bit. A match is then expected even though the window reads 001. Long runs with `bit_vld` low and changing `din` are placed between valid bits so that any leakage of idle cycles into the state shows up in the history words.

// File: rtl/spot_pkg.sv
// Package spot_pkg
// Shared widths and the progress-state encoding for the sequence detector.
// Assumes a three-bit pattern; the state count is tied to that width.
package spot_pkg;
    localparam int PAT_W  = 3;
    localparam int HIST_W = 8;

    typedef enum logic [1:0] {
        PROG_NONE = 2'b00,
        PROG_ONE  = 2'b01,
        PROG_TWO  = 2'b10,
        PROG_BAD  = 2'b11
    } prog_e;
endpackage

// File: rtl/spot_progress.sv
// Module spot_progress
// Mealy progress machine: counts leading pattern bits matched so far and
// flags the bit that completes the pattern. Handles overlap by falling back
// to the longest leading part of the pattern that ends the bits just seen.
// Assumes pattern bit PAT_W-1 is the oldest; advances only when step_i is high.
module spot_progress
    import spot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             bit_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic             hit_o
);
    localparam int P_FIRST = PAT_W - 1;
    localparam int P_MID   = PAT_W - 2;
    localparam int P_LAST  = PAT_W - 3;

    prog_e state_q;
    prog_e state_d;
    logic  has_prev;
    logic  prev_bit;
    logic  full;

    // Next progress value and completion flag from state, bit and pattern.
    always_comb begin
        has_prev = 1'b0;
        prev_bit = 1'b0;
        case (state_q)
            PROG_ONE: begin has_prev = 1'b1; prev_bit = pat_i[P_FIRST]; end
            PROG_TWO: begin has_prev = 1'b1; prev_bit = pat_i[P_MID];   end
            default:  begin has_prev = 1'b0; prev_bit = 1'b0;           end
        endcase
        full = (state_q == PROG_TWO) && (bit_i == pat_i[P_LAST]);
        if (state_q == PROG_BAD)
            state_d = PROG_NONE;
        else if (has_prev && (prev_bit == pat_i[P_FIRST]) && (bit_i == pat_i[P_MID]))
            state_d = PROG_TWO;
        else if (bit_i == pat_i[P_FIRST])
            state_d = PROG_ONE;
        else
            state_d = PROG_NONE;
    end

    // Progress register: clears on reset, advances on valid bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PROG_NONE;
        else if (step_i)
            state_q <= state_d;
    end

    assign hit_o = step_i && full;

    assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(state_q));
    assert_state_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != PROG_BAD);
    assert_hit_needs_two_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (state_q == PROG_TWO));
endmodule

// File: rtl/spot_hist.sv
// Module spot_hist
// Right-shifting history word: a new bit enters the top bit on each enabled
// clock and the oldest falls off bit 0. Observation only; nothing reads it back.
module spot_hist #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] q
);
    // Shift on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (shift_en)
            q <= {bit_in, q[W-1:1]};
    end

    assert_shift_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (q[W-2:0] == $past(q[W-1:1])));
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(q));
endmodule

// File: rtl/pattern_spotter.sv
// Module pattern_spotter
// Top of the programmable serial sequence detector: progress machine plus two
// history words (input bits and match results). Assumes one bit per clock,
// qualified by bit_vld, with a synchronous active-low reset.
module pattern_spotter
    import spot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              din,
    input  logic [PAT_W-1:0]  pattern_i,
    output logic              match_o,
    output logic [HIST_W-1:0] in_hist_o,
    output logic [HIST_W-1:0] match_hist_o
);
    logic hit;

    spot_progress u_prog (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (bit_vld),
        .bit_i  (din),
        .pat_i  (pattern_i),
        .hit_o  (hit)
    );

    spot_hist #(.W(HIST_W)) u_in_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .bit_in   (din),
        .q        (in_hist_o)
    );

    spot_hist #(.W(HIST_W)) u_match_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (bit_vld),
        .bit_in   (hit),
        .q        (match_hist_o)
    );

    assign match_o = hit;

    assert_match_logged_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> (match_hist_o[HIST_W-1] == $past(match_o)));
    assert_input_logged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> (in_hist_o[HIST_W-1] == $past(din)));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !match_o);
endmodule

// File: tb/pattern_spotter_tb.sv
module pattern_spotter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // Each entry: {pattern[2:0], stream[11:0] sent bit 11 first, expected match count[3:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {3'b010, 12'h540, 4'd3},
        {3'b000, 12'h0F0, 4'd4},
        {3'b111, 12'h0F0, 4'd2},
        {3'b110, 12'hDB6, 4'd4},
        {3'b101, 12'hAA5, 4'd4},
        {3'b011, 12'h333, 4'd3},
        {3'b100, 12'h910, 4'd3},
        {3'b001, 12'h131, 4'd3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_vld = 1'b0;
    logic       din = 1'b0;
    logic [2:0] pattern_i = 3'b000;
    logic       match_o;
    logic [7:0] in_hist_o;
    logic [7:0] match_hist_o;

    int total = 0;
    int bad = 0;
    int mstate = 0;
    logic [7:0] exp_in = '0;
    logic [7:0] exp_out = '0;
    int hits = 0;

    pattern_spotter dut_i (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .din(din),
        .pattern_i(pattern_i), .match_o(match_o),
        .in_hist_o(in_hist_o), .match_hist_o(match_hist_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Brute-force model: longest proper leading part of the pattern ending s.
    function automatic int model_next(input logic [2:0] p, input int k, input logic b);
        logic s [3];
        int n = k + 1;
        int best = 0;
        for (int j = 0; j < 3; j++) s[j] = (j < k) ? p[2-j] : b;
        for (int len = 1; len <= 2; len++) begin
            if (len <= n) begin
                logic ok = 1'b1;
                for (int t = 0; t < len; t++)
                    if (s[n-len+t] != p[2-t]) ok = 1'b0;
                if (ok) best = len;
            end
        end
        return best;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        mstate = 0; exp_in = '0; exp_out = '0;
    endtask

    // One valid bit: check the Mealy flag before the edge, histories after it.
    task automatic send(input logic b, input string req);
        logic m;
        @(negedge clk);
        bit_vld = 1'b1; din = b;
        #1;
        m = (mstate == 2) && (b == pattern_i[0]);
        check(req, match_o, m);
        if (m) hits++;
        @(posedge clk);
        mstate = model_next(pattern_i, mstate, b);
        exp_in = {b, exp_in[7:1]};
        exp_out = {m, exp_out[7:1]};
        #1;
        check("R5", in_hist_o, exp_in);
        check("R6", match_hist_o, exp_out);
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        #1;
        check("R1", in_hist_o, 8'h00);
        check("R1", match_hist_o, 8'h00);
        check("R1", match_o, 1'b0);

        // Vector table (R2, R3, R4, R9)
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            pattern_i = VEC[v][18:16];
            hits = 0;
            for (int i = 11; i >= 0; i--) send(VEC[v][4+i], "R4");
            check((v == 0) ? "R3" : "R9", hits, VEC[v][3:0]);
        end

        // R7: idle cycles with toggling din change nothing
        do_reset();
        pattern_i = 3'b000;
        send(1'b0, "R2"); send(1'b0, "R2");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            bit_vld = 1'b0; din = i[0];
            #1;
            check("R7", match_o, 1'b0);
        end
        #1;
        check("R7", in_hist_o, exp_in);
        check("R7", match_hist_o, exp_out);
        send(1'b0, "R2");
        check("R2", match_hist_o[7], 1'b1);

        // R8: progress kept across a pattern change
        do_reset();
        pattern_i = 3'b000;
        send(1'b0, "R8"); send(1'b0, "R8");
        @(negedge clk);
        pattern_i = 3'b011;
        send(1'b1, "R8");
        check("R8", match_hist_o[7], 1'b1);

        // R1: reset mid-stream clears progress and histories
        pattern_i = 3'b111;
        send(1'b1, "R1"); send(1'b1, "R1");
        do_reset();
        #1;
        check("R1", in_hist_o, 8'h00);
        send(1'b1, "R1");
        check("R1", match_hist_o, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule